// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing controller of a byte-addressed serial EEPROM that sits on a two-wire clock/data bus as a slave. A fast system clock oversamples the bus clock and data lines. The block finds Start and Stop conditions and decodes the control byte against a fixed device code and three strap inputs. It then takes in a two-byte word address and carries out writes and reads on an internal byte array. That array is a register memory whose size is set by a parameter.

Writes are gathered into a page buffer and reach the array only when a Stop arrives. After that commit, a programming period of parameterised length begins. During that period the block does not answer to its own control byte. A write-protect input stops data from being stored, but reads still work. Reads can start at the current pointer or at an address loaded by a preceding write header with a repeated Start. They go on byte by byte while the master keeps acknowledging. The data line is driven only through an active-high pull-low enable.

Top module: `eeprom2w_slave`

## Requirements
- R1: After reset, the pull-low enable is released, the address pointer is 0 and every array byte reads 0.
- R2: A Start (data falls while clock is high) re-arms reception. The first byte is taken MSB first. Bits 7:4 must equal 1010, bits 3:1 must equal `chipSel[2:0]`, and bit 0 selects read (1) or write (0). On a match the control byte is acknowledged.
- R3: A control byte whose code or select bits do not match gets no acknowledge. Every later byte gets no acknowledge and changes nothing until the next Start.
- R4: Each accepted byte (control, both address bytes, data) is acknowledged by pulling data low through the whole high phase of the ninth clock.
- R5: After a write control byte, two address bytes follow, high byte first. Bit 7 of the high byte is ignored, and of the remaining 15 bits only the low `ARRAY_AW` bits (default 10) select a byte.
- R6: In a page write, the low `PAGE_AW` bits (default 6) of the pointer advance and wrap inside the page. Later bytes overwrite earlier ones, and the upper pointer bits stay unchanged.
- R7: Written data reaches the array only at a Stop. A Start that arrives before the Stop throws away the pending bytes.
- R8: A Stop that commits at least one byte starts a busy period of `PROG_CYCLES` system clocks. During that period the control byte gets no acknowledge. A write header with no data bytes starts no busy period.
- R9: While `wrProtect` is high, data bytes are still acknowledged and still advance the pointer, but they are not stored, and no busy period follows.
- R10: A read control byte starts at the current pointer. After a write, the pointer is one past the last byte written (wrapped within the page). After an address header, the pointer equals the loaded address.
- R11: While the master acknowledges, the next byte follows at pointer+1, and the pointer wraps from the top of the array to 0.
- R12: After the master does not acknowledge a read byte, the data line stays released until the next Start.
- R13: The pull-low enable changes only while the synchronised bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| chipSel | input | 3 | Strap value compared with control byte bits 3:1 |
| wrProtect | input | 1 | High blocks storing of written data |
| sdaOe | output | 1 | High pulls the bus data line low |

## Verification
The assertions assume a master that changes data only while the clock is low, except when it makes a Start or a Stop. They also assume that each clock phase lasts several system clocks longer than the two-flop synchroniser delay. Under those assumptions the enable moves only in low phases, and a Start always finds the enable released. The bench master drives in quarter periods of eight system clocks. It changes data a quarter period after each clock fall and never overlaps a Start with a byte the slave is acknowledging, so every sequence stays inside those limits.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK} busState_t;
  typedef enum logic [1:0] {BY_CTRL, BY_AHI, BY_ALO, BY_DATA} byteKind_t;

  typedef struct packed {
    logic       setHi;
    logic       setLo;
    logic       wrData;
    logic       rdAdv;
    logic       commit;
    logic       discard;
    logic [7:0] byteVal;
  } dpCmd_t;

  localparam logic [3:0] CTRL_CODE = 4'b1010;
endpackage

// File: rtl/ee2w_sync.sv
module ee2w_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) chain[0] <= RESET_VAL;
        else       chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) chain[s] <= RESET_VAL;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ee2w_ctrl.sv
module ee2w_ctrl
  import ee2w_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic [2:0] chipSel,
  input  logic       busy,
  input  logic [7:0] rdByte,
  output logic       sdaOe,
  output dpCmd_t     cmd
);
  logic sclPrev, sdaPrev;
  logic sclRise, sclFall, startEv, stopEv;
  busState_t state;
  byteKind_t kind;
  logic [3:0] bitCnt;
  logic [7:0] shReg, txSh;
  logic isRead, masterNack;
  logic ctrlMatch, byteAck, byteDone, rdLoad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;

  assign ctrlMatch = (shReg[7:4] == CTRL_CODE) && (shReg[3:1] == chipSel) && !busy;
  assign byteAck   = (kind == BY_CTRL) ? ctrlMatch : !busy;
  assign byteDone  = (state == ST_RX) && sclFall && (bitCnt == 4'd8);
  assign rdLoad    = sclFall && !startEv && !stopEv &&
                     (((state == ST_ACK) && isRead) || ((state == ST_RACK) && !masterNack));

  always_comb begin
    cmd = '0;
    cmd.byteVal = shReg;
    cmd.commit  = stopEv;
    cmd.discard = startEv;
    cmd.rdAdv   = rdLoad;
    if (byteDone && byteAck) begin
      unique case (kind)
        BY_AHI:  cmd.setHi  = 1'b1;
        BY_ALO:  cmd.setLo  = 1'b1;
        BY_DATA: cmd.wrData = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      kind       <= BY_CTRL;
      bitCnt     <= '0;
      shReg      <= '0;
      txSh       <= '0;
      isRead     <= 1'b0;
      masterNack <= 1'b1;
      sdaOe      <= 1'b0;
    end else if (startEv) begin
      state  <= ST_RX;
      kind   <= BY_CTRL;
      bitCnt <= '0;
      isRead <= 1'b0;
      sdaOe  <= 1'b0;
    end else if (stopEv) begin
      state <= ST_IDLE;
      sdaOe <= 1'b0;
    end else if (rdLoad) begin
      sdaOe  <= ~rdByte[7];
      txSh   <= {rdByte[6:0], 1'b0};
      bitCnt <= 4'd1;
      state  <= ST_TX;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            shReg  <= {shReg[6:0], sdaS};
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            if (byteAck) begin
              sdaOe <= 1'b1;
              state <= ST_ACK;
              unique case (kind)
                BY_CTRL: begin
                  isRead <= shReg[0];
                  if (!shReg[0]) kind <= BY_AHI;
                end
                BY_AHI:  kind <= BY_ALO;
                BY_ALO:  kind <= BY_DATA;
                default: ;
              endcase
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            sdaOe  <= 1'b0;
            bitCnt <= '0;
            state  <= ST_RX;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd8) begin
              sdaOe <= 1'b0;
              state <= ST_RACK;
            end else begin
              sdaOe  <= ~txSh[7];
              txSh   <= {txSh[6:0], 1'b0};
              bitCnt <= bitCnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise)      masterNack <= sdaS;
          else if (sclFall) state <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  // R13: enable only moves in a cycle that follows a low bus clock sample
  p_oe_scl_low_r13: assert property (@(posedge clk) disable iff (!rstN)
    $past(sclS) |-> $stable(sdaOe))
    else $error("sdaOe changed while bus clock high");

  // R2: a Start re-arms the byte receiver with the line released
  p_start_rearm_r2: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> (state == ST_RX) && (bitCnt == 4'd0) && !sdaOe)
    else $error("start did not re-arm receiver");

  // R12: master NACK leaves the slave idle and silent
  p_nack_release_r12: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACK) && sclFall && masterNack |=> (state == ST_IDLE) && !sdaOe)
    else $error("line not released after master nack");

  // R8: no acknowledge of a control byte while busy
  p_busy_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && byteDone && (kind == BY_CTRL) |=> !sdaOe)
    else $error("control byte acknowledged while busy");
endmodule

// File: rtl/ee2w_store.sv
module ee2w_store
  import ee2w_pkg::*;
#(
  parameter int ARRAY_AW    = 10,
  parameter int PAGE_AW     = 6,
  parameter int PROG_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrProtect,
  input  dpCmd_t     cmd,
  output logic [7:0] rdByte,
  output logic       busy
);
  localparam int DEPTH = 1 << ARRAY_AW;
  localparam int PAGE  = 1 << PAGE_AW;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam int UP_W  = ARRAY_AW - PAGE_AW;

  logic [7:0]          mem [DEPTH];
  logic [7:0]          pageBuf [PAGE];
  logic [PAGE-1:0]     pageValid;
  logic [6:0]          addrHi;
  logic [ARRAY_AW-1:0] ptr;
  logic [CNT_W-1:0]    busyCnt;

  assign busy   = (busyCnt != '0);
  assign rdByte = mem[ptr];

  always_ff @(posedge clk) begin
    if (cmd.wrData && !wrProtect) pageBuf[ptr[PAGE_AW-1:0]] <= cmd.byteVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      pageValid <= '0;
      addrHi    <= '0;
      ptr       <= '0;
      busyCnt   <= '0;
    end else begin
      if (cmd.commit && (pageValid != '0)) begin
        for (int i = 0; i < PAGE; i++) begin
          if (pageValid[i]) mem[{ptr[ARRAY_AW-1:PAGE_AW], PAGE_AW'(i)}] <= pageBuf[i];
        end
        busyCnt <= CNT_W'(PROG_CYCLES);
      end else if (busy) begin
        busyCnt <= busyCnt - 1'b1;
      end

      if (cmd.commit || cmd.discard) pageValid <= '0;
      else if (cmd.wrData && !wrProtect) pageValid[ptr[PAGE_AW-1:0]] <= 1'b1;

      if (cmd.setHi) addrHi <= cmd.byteVal[6:0];

      if (cmd.setLo)       ptr <= ARRAY_AW'({addrHi, cmd.byteVal});
      else if (cmd.wrData) ptr <= {ptr[ARRAY_AW-1:PAGE_AW], ptr[PAGE_AW-1:0] + 1'b1};
      else if (cmd.rdAdv)  ptr <= ptr + 1'b1;
    end
  end

  // R6: a data byte moves only the in-page bits, wrapping
  p_page_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrData |=> (ptr[PAGE_AW-1:0] == PAGE_AW'($past(ptr[PAGE_AW-1:0]) + 1)) &&
                   (ptr[ARRAY_AW-1:PAGE_AW] == $past(ptr[ARRAY_AW-1:PAGE_AW])))
    else $error("page pointer did not wrap in page");

  // R11: read advance wraps at array top
  p_seq_wrap_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rdAdv |=> ptr == ARRAY_AW'($past(ptr) + 1))
    else $error("read pointer advance wrong");

  // R8: busy only begins right after a commit strobe
  p_busy_after_commit_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmd.commit))
    else $error("busy started without commit");

  // R9: protected data never enters the pending page
  p_wp_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrData && wrProtect |=> pageValid == $past(pageValid))
    else $error("protected byte marked pending");

  // R7: nothing is pending while the programming cycle runs
  p_busy_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> pageValid == '0)
    else $error("pending data during busy");

  if (UP_W < 1) begin : g_bad_cfg
    initial $error("ARRAY_AW must exceed PAGE_AW");
  end
endmodule

// File: rtl/eeprom2w_slave.sv
module eeprom2w_slave
  import ee2w_pkg::*;
#(
  parameter int ARRAY_AW    = 10,
  parameter int PAGE_AW     = 6,
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipSel,
  input  logic       wrProtect,
  output logic       sdaOe
);
  logic sclS, sdaS, busy;
  logic [7:0] rdByte;
  dpCmd_t cmd;

  ee2w_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  ee2w_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  ee2w_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS), .chipSel(chipSel),
    .busy(busy), .rdByte(rdByte), .sdaOe(sdaOe), .cmd(cmd));

  ee2w_store #(.ARRAY_AW(ARRAY_AW), .PAGE_AW(PAGE_AW), .PROG_CYCLES(PROG_CYCLES)) i_store (
    .clk(clk), .rstN(rstN), .wrProtect(wrProtect), .cmd(cmd),
    .rdByte(rdByte), .busy(busy));
endmodule

// File: tb/test_eeprom2w_slave.sv
module test_eeprom2w_slave;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int PROG  = 1000;
  localparam int Q     = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSdaLow = 1'b0;
  logic [2:0] chipSel = 3'b101;
  logic wp = 1'b0;
  logic sdaOe;
  logic sda;
  assign sda = !(mSdaLow || sdaOe);

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] mdl [DEPTH];
  int mPtr = 0;
  logic [7:0] wbuf [80];

  always #4 clk = ~clk;

  eeprom2w_slave #(.ARRAY_AW(AW), .PAGE_AW(6), .PROG_CYCLES(PROG)) i_eeprom2w_slave (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda), .chipSel(chipSel),
    .wrProtect(wp), .sdaOe(sdaOe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // R13 monitor: enable must hold during each bus clock high phase
  logic sclPrevTb = 1'b1;
  logic oeHold = 1'b0;
  bit oeMoved = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (scl && !sclPrevTb) begin
        oeHold = sdaOe;
        oeMoved = 0;
      end else if (scl && sdaOe !== oeHold) begin
        oeMoved = 1;
      end
      if (!scl && sclPrevTb) chk(!oeMoved, "R13", int'(oeMoved), 0);
    end
    sclPrevTb = scl;
  end

  task automatic busStart();
    mSdaLow = 0; wt(Q);
    scl = 1;     wt(Q);
    mSdaLow = 1; wt(Q);
    scl = 0;     wt(Q);
  endtask

  task automatic busStop();
    mSdaLow = 1; wt(Q);
    scl = 1;     wt(Q);
    mSdaLow = 0; wt(Q);
  endtask

  task automatic clockBit(input bit drv, output bit seen);
    mSdaLow = !drv; wt(Q);
    scl = 1;        wt(Q);
    seen = sda;     wt(Q);
    scl = 0;        wt(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    acked = !s;
  endtask

  task automatic recvByte(output logic [7:0] b, input bit masterAck);
    bit s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, s);
      b = {b[6:0], s};
    end
    clockBit(!masterAck, s);
  endtask

  function automatic logic [7:0] ctrlByte(input logic [2:0] cs, input bit rd);
    return {4'b1010, cs, rd};
  endfunction

  task automatic readBytes(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recvByte(b, k != n - 1);
      chk(b === mdl[mPtr], req, int'(b), int'(mdl[mPtr]));
      mPtr = (mPtr + 1) % DEPTH;
    end
  endtask

  // header: Start, write control, two address bytes (R2, R4, R5)
  task automatic sendHeader(input logic [15:0] addr);
    bit a;
    busStart();
    sendByte(ctrlByte(chipSel, 1'b0), a); chk(a, "R2", int'(a), 1);
    sendByte(addr[15:8], a);              chk(a, "R4", int'(a), 1);
    sendByte(addr[7:0], a);               chk(a, "R4", int'(a), 1);
    mPtr = int'(addr[AW-1:0]);
  endtask

  task automatic doWrite(input logic [15:0] addr, input int n, input bit store, input bit waitDone);
    bit a;
    int base, pg, off;
    sendHeader(addr);
    base = int'(addr[AW-1:0]);
    pg = base - (base % 64);
    off = base % 64;
    for (int k = 0; k < n; k++) begin
      sendByte(wbuf[k], a);
      chk(a, store ? "R4" : "R9", int'(a), 1);
      if (store) mdl[pg + ((off + k) % 64)] = wbuf[k];
    end
    mPtr = pg + ((off + n) % 64);
    busStop();
    if (waitDone) wt((store && n > 0) ? PROG + 300 : 20);
  endtask

  task automatic doRandomRead(input logic [15:0] addr, input int n, input string req);
    bit a;
    sendHeader(addr);
    busStart();
    sendByte(ctrlByte(chipSel, 1'b1), a); chk(a, "R2", int'(a), 1);
    readBytes(n, req);
    busStop();
    wt(20);
  endtask

  task automatic doCurrentRead(input int n, input string req);
    bit a;
    busStart();
    sendByte(ctrlByte(chipSel, 1'b1), a); chk(a, req, int'(a), 1);
    readBytes(n, req);
    busStop();
    wt(20);
  endtask

  initial begin
    wt(190000);
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    bit a;
    logic [7:0] b;
    for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
    wt(5);
    chk(sdaOe === 1'b0, "R1", int'(sdaOe), 0);
    rstN = 1'b1;
    wt(10);
    chk(sdaOe === 1'b0, "R1", int'(sdaOe), 0);

    // R1 / R10: current read from reset pointer 0 gives 0
    doCurrentRead(2, "R1");

    // R2 R4: single byte write then random read
    wbuf[0] = 8'hA5;
    doWrite(16'h0005, 1, 1, 1);
    doRandomRead(16'h0005, 1, "R2");

    // R5: high-byte bit 7 and bits above array width ignored
    wbuf[0] = 8'h3C;
    doWrite(16'h8123, 1, 1, 1);
    doRandomRead(16'h0123, 1, "R5");
    doRandomRead(16'h4123, 1, "R5");

    // R6: 66 bytes from page offset 62 wrap and overwrite
    for (int k = 0; k < 66; k++) wbuf[k] = 8'(k + 8'h40);
    doWrite(16'h007E, 66, 1, 1);
    doRandomRead(16'h0040, 64, "R6");
    doRandomRead(16'h0080, 1, "R6");

    // R8: control byte during busy is refused, accepted afterwards
    wbuf[0] = 8'h77;
    doWrite(16'h0200, 1, 1, 0);
    busStart();
    sendByte(ctrlByte(chipSel, 1'b1), a);
    chk(!a, "R8", int'(a), 0);
    busStop();
    wt(PROG + 300);
    doCurrentRead(1, "R10");        // pointer one past last written byte
    doRandomRead(16'h0200, 1, "R8");

    // R8 / R10: header-only write sets pointer, starts no busy
    doWrite(16'h0005, 0, 1, 0);
    doCurrentRead(1, "R10");

    // R7: Start before Stop discards pending data
    sendHeader(16'h0300);
    sendByte(8'h11, a); chk(a, "R4", int'(a), 1);
    sendByte(8'h22, a); chk(a, "R4", int'(a), 1);
    mPtr = 16'h0302;
    busStart();
    sendByte(ctrlByte(chipSel, 1'b1), a); chk(a, "R7", int'(a), 1);
    readBytes(1, "R7");
    busStop();
    wt(20);
    doRandomRead(16'h0300, 2, "R7");

    // R9: write protect blocks storage, no busy period
    wp = 1'b1;
    wbuf[0] = 8'h5A;
    doWrite(16'h0005, 1, 0, 0);
    doRandomRead(16'h0005, 1, "R9");
    wp = 1'b0;
    wt(20);

    // R11: sequential read wraps from array top to 0
    wbuf[0] = 8'hC1;
    wbuf[1] = 8'hC2;
    doWrite(16'h03FE, 2, 1, 1);
    doRandomRead(16'h03FE, 4, "R11");

    // R3: mismatching select or code gets no ack and writes nothing
    busStart();
    sendByte(ctrlByte(chipSel ^ 3'b001, 1'b0), a); chk(!a, "R3", int'(a), 0);
    sendByte(8'h00, a); chk(!a, "R3", int'(a), 0);
    sendByte(8'h05, a); chk(!a, "R3", int'(a), 0);
    sendByte(8'hEE, a); chk(!a, "R3", int'(a), 0);
    busStop();
    busStart();
    sendByte({4'b1011, chipSel, 1'b0}, a); chk(!a, "R3", int'(a), 0);
    busStop();
    wt(PROG + 300);
    doRandomRead(16'h0005, 1, "R3");

    // R12: after master NACK the line stays released
    doRandomRead(16'h0040, 1, "R11");
    busStart();
    sendByte(ctrlByte(chipSel, 1'b1), a); chk(a, "R12", int'(a), 1);
    readBytes(1, "R12");
    recvByte(b, 1'b0);
    chk(b === 8'hFF, "R12", int'(b), 8'hFF);
    chk(sdaOe === 1'b0, "R12", int'(sdaOe), 0);
    busStop();
    wt(20);

    // R2: new strap value selects the device
    chipSel = 3'b010;
    wt(10);
    wbuf[0] = 8'h9D;
    doWrite(16'h0010, 1, 1, 1);
    doRandomRead(16'h0010, 1, "R2");
    busStart();
    sendByte(ctrlByte(3'b101, 1'b1), a); chk(!a, "R3", int'(a), 0);
    busStop();
    wt(20);

    finishRun();
  end
endmodule